// File: doc/BRIEF.md
# Ready/Busy Output Mode Controller

This block produces the pull-low enable for an open-drain ready/busy pin from the status signals of an internal write/erase sequencer. A host selects one of four pin behaviours with a two-write configuration command. The first write carries 96h. The second write carries a code that picks the behaviour. In level mode the pin follows the sequencer's busy state. In the two pulse modes the pin gives a short fixed-length low pulse each time a write or an erase finishes. In disabled mode the pin never drives.

The pin is released whenever the device is in deep power-down or an erase is suspended. It is never gated by chip-select or output-enable style signals: only the disable code stops it. An active-low reset/power-down input aborts any half-entered command and returns the controller to level mode. The output `pull_low` models the pad: 1 drives the line low and 0 leaves it to the external pull-up.

Top module: `rdybsy_ctrl`

## Requirements
- R1: After a command write of 96h, the next command write selects the mode, visible on `mode` from the cycle after that second write. The codes are 01h for level (mode 0), 02h for pulse-on-write (mode 1), 03h for pulse-on-erase (mode 2) and 04h for disabled (mode 3).
- R2: While and after reset, `mode` is 0 (level), `cfg_err` is 0 and any half-entered command is dropped.
- R3: In level mode, `pull_low` is 1 exactly when `wsm_busy` is 1, `ers_susp` is 0 and `pwr_down` is 0.
- R4: While `pwr_down` is 1, `pull_low` is 0 in every mode.
- R5: In disabled mode, `pull_low` is 0 whatever the status inputs do.
- R6: In pulse-on-write mode, `wr_done` high at a clock edge makes `pull_low` 1 for exactly PULSE_LEN cycles starting after that edge; `ers_done` has no effect.
- R7: In pulse-on-erase mode, `ers_done` high at a clock edge makes `pull_low` 1 for exactly PULSE_LEN cycles starting after that edge; `wr_done` has no effect.
- R8: In either pulse mode the level of `wsm_busy` does not drive the pin; outside a pulse `pull_low` is 0.
- R9: A second write whose data is not 01h to 04h leaves `mode` unchanged and sets `cfg_err`. `cfg_err` stays set until a later valid configuration or reset clears it.
- R10: A command write that does not follow a 96h write leaves `mode` and `cfg_err` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset/power-down, asynchronous |
| cmd_we | input | 1 | Command write strobe, one write per cycle high |
| cmd_data | input | 8 | Command write data |
| wsm_busy | input | 1 | Sequencer has pending or running operations |
| ers_susp | input | 1 | An erase is suspended |
| pwr_down | input | 1 | Device is in deep power-down |
| wr_done | input | 1 | One-cycle event: a data write completed |
| ers_done | input | 1 | One-cycle event: an erase completed |
| pull_low | output | 1 | 1 drives the pin low, 0 releases it |
| mode | output | 2 | Current mode: 0 level, 1 pulse-on-write, 2 pulse-on-erase, 3 disabled |
| cfg_err | output | 1 | Last configuration code was invalid |

## Verification
Mode and error changes land one clock edge after the second command write, so the bench applies both writes on falling edges and reads `mode` and `cfg_err` at the falling edge after the second one. Level-mode and power-down gating is combinational from the status inputs, so it is read a short delay after the inputs change and before the next edge. A completion event sampled at an edge raises the pin from that edge for PULSE_LEN cycles. The bench checks the pin high at each of the PULSE_LEN falling edges that follow and low at the next one.

// File: rtl/rdybsy_pkg.sv
package rdybsy_pkg;

  typedef enum logic [1:0] {
    MODE_LEVEL = 2'd0,
    MODE_PWR   = 2'd1,
    MODE_PER   = 2'd2,
    MODE_OFF   = 2'd3
  } rb_mode_t;

  localparam logic [7:0] CMD_PREFIX = 8'h96;

  typedef struct packed {
    logic     ok;
    rb_mode_t m;
  } rb_code_t;

  // Map a second-cycle code to a mode; ok is low for unknown codes.
  function automatic rb_code_t code_to_mode(input logic [7:0] d);
    rb_code_t r;
    r.ok = 1'b1;
    r.m  = MODE_LEVEL;
    case (d)
      8'h01:   r.m = MODE_LEVEL;
      8'h02:   r.m = MODE_PWR;
      8'h03:   r.m = MODE_PER;
      8'h04:   r.m = MODE_OFF;
      default: r.ok = 1'b0;
    endcase
    return r;
  endfunction

  // Next value of a pulse down-counter: reload on trigger, else count to zero.
  function automatic int unsigned pulse_next(input int unsigned cur,
                                             input logic trig,
                                             input int unsigned len);
    if (trig)          return len;
    else if (cur != 0) return cur - 1;
    else               return 0;
  endfunction

endpackage

// File: rtl/rdybsy_cmd_dec.sv
module rdybsy_cmd_dec
  import rdybsy_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_data,
  output rb_mode_t   mode_q,
  output logic       err_q
);

  logic     armed_q;
  rb_code_t code;

  assign code = code_to_mode(cmd_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      mode_q  <= MODE_LEVEL;
      err_q   <= 1'b0;
    end else if (cmd_we) begin
      if (armed_q) begin
        armed_q <= 1'b0;
        if (code.ok) begin
          mode_q <= code.m;
          err_q  <= 1'b0;
        end else begin
          err_q  <= 1'b1;
        end
      end else if (cmd_data == CMD_PREFIX) begin
        armed_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rdybsy_pulse.sv
module rdybsy_pulse
  import rdybsy_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic keep,
  output logic active
);

  localparam int unsigned CW = $clog2(PULSE_LEN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (!keep) cnt_q <= '0;
    else            cnt_q <= CW'(pulse_next(int'(cnt_q), trig, PULSE_LEN));
  end

  assign active = (cnt_q != '0);

endmodule

// File: rtl/rdybsy_drive.sv
module rdybsy_drive
  import rdybsy_pkg::*;
(
  input  rb_mode_t mode,
  input  logic     wsm_busy,
  input  logic     ers_susp,
  input  logic     pwr_down,
  input  logic     pulse_act,
  output logic     pull_low
);

  always_comb begin
    pull_low = 1'b0;
    unique case (mode)
      MODE_LEVEL:         pull_low = wsm_busy & ~ers_susp;
      MODE_PWR, MODE_PER: pull_low = pulse_act;
      MODE_OFF:           pull_low = 1'b0;
    endcase
    if (pwr_down) pull_low = 1'b0;
  end

endmodule

// File: rtl/rdybsy_ctrl.sv
module rdybsy_ctrl
  import rdybsy_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_data,
  input  logic       wsm_busy,
  input  logic       ers_susp,
  input  logic       pwr_down,
  input  logic       wr_done,
  input  logic       ers_done,
  output logic       pull_low,
  output logic [1:0] mode,
  output logic       cfg_err
);

  rb_mode_t mode_q;
  logic     ev_pulse_trig;
  logic     ev_pulse_mode;
  logic     pulse_act;

  rdybsy_cmd_dec u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_we   (cmd_we),
    .cmd_data (cmd_data),
    .mode_q   (mode_q),
    .err_q    (cfg_err)
  );

  assign ev_pulse_mode = (mode_q == MODE_PWR) || (mode_q == MODE_PER);
  assign ev_pulse_trig = ((mode_q == MODE_PWR) && wr_done) ||
                         ((mode_q == MODE_PER) && ers_done);

  rdybsy_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig   (ev_pulse_trig),
    .keep   (ev_pulse_mode),
    .active (pulse_act)
  );

  rdybsy_drive u_drive (
    .mode      (mode_q),
    .wsm_busy  (wsm_busy),
    .ers_susp  (ers_susp),
    .pwr_down  (pwr_down),
    .pulse_act (pulse_act),
    .pull_low  (pull_low)
  );

  assign mode = mode_q;

endmodule

// File: rtl/rdybsy_ctrl_chk.sv
module rdybsy_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_we,
  input logic       wsm_busy,
  input logic       ers_susp,
  input logic       pwr_down,
  input logic       pull_low,
  input logic [1:0] mode,
  input logic       cfg_err,
  input logic       ev_pulse_trig
);

  p_reset_default_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mode == 2'd0 && !cfg_err));

  p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> (pull_low == (wsm_busy && !ers_susp && !pwr_down)));

  p_pd_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> !pull_low);

  p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> !pull_low);

  p_pulse_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pulse_trig && !cmd_we) |=> (pull_low || pwr_down));

  p_bad_keeps_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> $stable(mode));

endmodule

bind rdybsy_ctrl rdybsy_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_we        (cmd_we),
  .wsm_busy      (wsm_busy),
  .ers_susp      (ers_susp),
  .pwr_down      (pwr_down),
  .pull_low      (pull_low),
  .mode          (mode),
  .cfg_err       (cfg_err),
  .ev_pulse_trig (ev_pulse_trig)
);

// File: tb/rdybsy_ctrl_test.sv
module rdybsy_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int PLEN = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic       wsm_busy = 1'b0, ers_susp = 1'b0, pwr_down = 1'b0;
  logic       wr_done = 1'b0, ers_done = 1'b0;
  logic       pull_low;
  logic [1:0] mode;
  logic       cfg_err;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdybsy_ctrl #(.PULSE_LEN(PLEN)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .wsm_busy(wsm_busy), .ers_susp(ers_susp), .pwr_down(pwr_down),
    .wr_done(wr_done), .ers_done(ers_done),
    .pull_low(pull_low), .mode(mode), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [7:0] code);
    @(negedge clk); cmd_we = 1'b1; cmd_data = 8'h96;
    @(negedge clk); cmd_data = code;
    @(negedge clk); cmd_we = 1'b0; cmd_data = 8'h00;
  endtask

  // Raise one event for a single edge, then expect PLEN high cycles.
  task automatic pulse_expect(input string req, input bit use_wr, input bit expect_pulse);
    @(negedge clk); wr_done = use_wr; ers_done = !use_wr;
    @(negedge clk); wr_done = 1'b0; ers_done = 1'b0;
    #1 check(req, pull_low, expect_pulse);
    for (int i = 1; i < PLEN; i++) begin
      @(negedge clk); #1 check(req, pull_low, expect_pulse);
    end
    @(negedge clk); #1 check(req, pull_low, 0);
  endtask

  task automatic t_reset;
    #1 check("R2 mode", mode, 0);
    check("R2 err", cfg_err, 0);
    check("R2 pin", pull_low, 0);
  endtask

  task automatic t_level;
    @(negedge clk); wsm_busy = 1'b1;
    #1 check("R3 busy", pull_low, 1);
    ers_susp = 1'b1; #1 check("R3 suspend", pull_low, 0);
    ers_susp = 1'b0; pwr_down = 1'b1; #1 check("R4 level", pull_low, 0);
    pwr_down = 1'b0; #1 check("R3 busy again", pull_low, 1);
    wsm_busy = 1'b0; #1 check("R3 ready", pull_low, 0);
  endtask

  task automatic t_unarmed;
    @(negedge clk); cmd_we = 1'b1; cmd_data = 8'h02;
    @(negedge clk); cmd_we = 1'b0; cmd_data = 8'h00;
    #1 check("R10 mode", mode, 0);
    check("R10 err", cfg_err, 0);
  endtask

  task automatic t_pulse_wr;
    cfg(8'h02);
    #1 check("R1 pulse-write", mode, 1);
    wsm_busy = 1'b1; #1 check("R8 busy ignored", pull_low, 0);
    wsm_busy = 1'b0;
    pulse_expect("R6 write pulse", 1'b1, 1'b1);
    pulse_expect("R6 erase ignored", 1'b0, 1'b0);
    pwr_down = 1'b1;
    pulse_expect("R4 pulse gated", 1'b1, 1'b0);
    pwr_down = 1'b0;
  endtask

  task automatic t_pulse_er;
    cfg(8'h03);
    #1 check("R1 pulse-erase", mode, 2);
    pulse_expect("R7 erase pulse", 1'b0, 1'b1);
    pulse_expect("R7 write ignored", 1'b1, 1'b0);
  endtask

  task automatic t_bad_and_off;
    cfg(8'h07);
    #1 check("R9 mode kept", mode, 2);
    check("R9 err set", cfg_err, 1);
    cfg(8'h04);
    #1 check("R1 disabled", mode, 3);
    check("R9 err cleared", cfg_err, 0);
    wsm_busy = 1'b1; #1 check("R5 busy", pull_low, 0);
    pulse_expect("R5 events", 1'b1, 1'b0);
    wsm_busy = 1'b0;
  endtask

  task automatic t_reset_again;
    cfg(8'h07);
    @(negedge clk); cmd_we = 1'b1; cmd_data = 8'h96;
    @(negedge clk); cmd_we = 1'b0; rst_n = 1'b0;
    #1 check("R2 mode", mode, 0);
    check("R2 err", cfg_err, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); cmd_we = 1'b1; cmd_data = 8'h03;
    @(negedge clk); cmd_we = 1'b0;
    #1 check("R2 prefix dropped", mode, 0);
    cfg(8'h02);
    cfg(8'h01);
    #1 check("R1 level", mode, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_level;
    t_unarmed;
    t_pulse_wr;
    t_pulse_er;
    t_bad_and_off;
    t_reset_again;
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule